// File: doc/BRIEF.md
# Pipeline Stage Throttle Controller

This block deliberately inserts short stalls into the front end of a superscalar pipeline after cycles of poor throughput, which relieves queue congestion and lowers switching power. Every cycle it samples the number of instructions that the fetch, decode and issue stages handled, together with the fetch-queue occupancy. Consider a stage that is running normally and that handled at least one instruction but no more than its threshold. That stage is then held for a programmable number of following cycles.

Each stage has its own small state machine with two named states. RUN is the normal state, and trigger samples are evaluated in it. HOLD is the throttle stall, and a down-counter runs in it. The transition RUN to HOLD ("engage") is taken on a trigger with a nonzero stall length, and loads the counter. The transition HOLD to RUN ("release") is taken when the counter reaches its last cycle. In every other case RUN stays in RUN ("idle") and HOLD stays in HOLD ("count"). While fetch is held, the enables for the instruction cache, the branch predictor and the memory bus are dropped. Separately, a cycle with no issued instructions sets an issue-idle gate for the following cycle.

Top module: `throttle_ctrl`

## Requirements
- R1: After reset, all three stall outputs are 0, the three fetch-side enables are 1 and issue_gate is 0.
- R2: When fetch is in RUN and a sampled fetch_cnt lies in 1..fetch_thr, fetch_stall is 1 for exactly fetch_len cycles, starting in the cycle after the sample.
- R3: When decode is in RUN, decode_stall is 1 for exactly decode_len cycles, starting in the cycle after the sample. The trigger is a sampled decode_cnt in 1..decode_thr, or a sampled fq_occ strictly below fq_thr.
- R4: When issue is in RUN and a sampled issue_cnt lies in 1..issue_thr, issue_stall is 1 for exactly issue_len cycles, starting in the cycle after the sample.
- R5: A count of 0 never starts a stall of its own stage.
- R6: A stall length of 0 means the stage never stalls.
- R7: A stall is never extended by triggers that arrive while it runs. A sample taken in any cycle in which that stage's stall output is 1 is ignored. The first sample taken after the stall ends is evaluated normally.
- R8: icache_en, bpred_en and membus_en are each 0 exactly in the cycles where fetch_stall is 1, and 1 otherwise.
- R9: issue_gate is 1 in the cycle after a sample with issue_cnt = 0, and 0 in the cycle after any other sample.
- R10: A count above its threshold (threshold+1 or more) does not start a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_cnt | input | CNT_W | Instructions fetched this cycle |
| decode_cnt | input | CNT_W | Instructions decoded this cycle |
| issue_cnt | input | CNT_W | Instructions issued this cycle |
| fq_occ | input | OCC_W | Fetch-queue occupancy |
| fetch_thr | input | CNT_W | Highest fetch count that triggers |
| decode_thr | input | CNT_W | Highest decode count that triggers |
| issue_thr | input | CNT_W | Highest issue count that triggers |
| fq_thr | input | OCC_W | Occupancy below which decode triggers |
| fetch_len | input | LEN_W | Fetch stall length in cycles |
| decode_len | input | LEN_W | Decode stall length in cycles |
| issue_len | input | LEN_W | Issue stall length in cycles |
| fetch_stall | output | 1 | Fetch stage held |
| decode_stall | output | 1 | Decode stage held |
| issue_stall | output | 1 | Issue stage held |
| icache_en | output | 1 | Instruction cache access enable |
| bpred_en | output | 1 | Branch predictor access enable |
| membus_en | output | 1 | Memory bus access enable |
| issue_gate | output | 1 | Issue stage clock gate (idle) |

## Verification
The bench goes after several corner cases, and a wrong design would show each one as a stall of the wrong length or at the wrong time.

- Threshold boundaries: a count equal to its threshold must trigger and a count one above it must not. A comparator that is off by one would stall one case too few or one too many.
- Zero counts and zero lengths: a design that treats zero as low throughput would stall on empty cycles, and a design that loads a zero length would hang in HOLD or wrap its counter.
- Triggers during a stall: a design that reloads its counter on these would stretch the stall. A design that samples on the release cycle would chain stalls back to back.
- Occupancy path of decode: a design that drops this path would miss decode stalls when decode counts are high.

// File: rtl/throttle_pkg.sv
package throttle_pkg;
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } thr_state_e;

    localparam int NUM_STAGES = 3;
    localparam int STG_FETCH  = 0;
    localparam int STG_DECODE = 1;
    localparam int STG_ISSUE  = 2;
endpackage

// File: rtl/throttle_trig.sv
module throttle_trig #(
    parameter int CNT_W = 3
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] thr,
    output logic             hit
);
    always_comb begin
        hit = (cnt != '0) && (cnt <= thr);
    end
endmodule

// File: rtl/stage_fsm.sv
module stage_fsm
    import throttle_pkg::*;
#(
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [LEN_W-1:0] len,
    output logic             stall
);
    localparam logic [LEN_W-1:0] LAST = LEN_W'(1);

    thr_state_e       state_q, state_d;
    logic [LEN_W-1:0] rem_q, rem_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        unique case (state_q)
            ST_RUN: begin
                if (hit && (len != '0)) begin
                    state_d = ST_HOLD;
                    rem_d   = len;
                end
            end
            ST_HOLD: begin
                rem_d = rem_q - LAST;
                if (rem_q == LAST) begin
                    state_d = ST_RUN;
                end
            end
            default: begin
                state_d = ST_RUN;
                rem_d   = '0;
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  stall = 1'b0;
            ST_HOLD: stall = 1'b1;
            default: stall = 1'b0;
        endcase
    end
endmodule

// File: rtl/throttle_ctrl.sv
module throttle_ctrl
    import throttle_pkg::*;
#(
    parameter int CNT_W = 3,
    parameter int OCC_W = 4,
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] fetch_cnt,
    input  logic [CNT_W-1:0] decode_cnt,
    input  logic [CNT_W-1:0] issue_cnt,
    input  logic [OCC_W-1:0] fq_occ,
    input  logic [CNT_W-1:0] fetch_thr,
    input  logic [CNT_W-1:0] decode_thr,
    input  logic [CNT_W-1:0] issue_thr,
    input  logic [OCC_W-1:0] fq_thr,
    input  logic [LEN_W-1:0] fetch_len,
    input  logic [LEN_W-1:0] decode_len,
    input  logic [LEN_W-1:0] issue_len,
    output logic             fetch_stall,
    output logic             decode_stall,
    output logic             issue_stall,
    output logic             icache_en,
    output logic             bpred_en,
    output logic             membus_en,
    output logic             issue_gate
);
    logic [CNT_W-1:0] cnt_a  [NUM_STAGES];
    logic [CNT_W-1:0] thr_a  [NUM_STAGES];
    logic [LEN_W-1:0] len_a  [NUM_STAGES];
    logic             cnt_hit[NUM_STAGES];
    logic             hit_a  [NUM_STAGES];
    logic             stall_a[NUM_STAGES];
    logic             occ_low;
    logic             gate_q;

    assign cnt_a[STG_FETCH]  = fetch_cnt;
    assign cnt_a[STG_DECODE] = decode_cnt;
    assign cnt_a[STG_ISSUE]  = issue_cnt;
    assign thr_a[STG_FETCH]  = fetch_thr;
    assign thr_a[STG_DECODE] = decode_thr;
    assign thr_a[STG_ISSUE]  = issue_thr;
    assign len_a[STG_FETCH]  = fetch_len;
    assign len_a[STG_DECODE] = decode_len;
    assign len_a[STG_ISSUE]  = issue_len;

    assign occ_low = (fq_occ < fq_thr);

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        throttle_trig #(.CNT_W(CNT_W)) u_trig (
            .cnt (cnt_a[s]),
            .thr (thr_a[s]),
            .hit (cnt_hit[s])
        );

        if (s == STG_DECODE) begin : g_occ
            assign hit_a[s] = cnt_hit[s] || occ_low;
        end else begin : g_plain
            assign hit_a[s] = cnt_hit[s];
        end

        stage_fsm #(.LEN_W(LEN_W)) u_fsm (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit_a[s]),
            .len   (len_a[s]),
            .stall (stall_a[s])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= (issue_cnt == '0);
    end

    always_comb begin
        fetch_stall  = stall_a[STG_FETCH];
        decode_stall = stall_a[STG_DECODE];
        issue_stall  = stall_a[STG_ISSUE];
        icache_en    = !stall_a[STG_FETCH];
        bpred_en     = !stall_a[STG_FETCH];
        membus_en    = !stall_a[STG_FETCH];
        issue_gate   = gate_q;
    end
endmodule

// File: rtl/throttle_chk.sv
module throttle_chk #(
    parameter int CNT_W = 3,
    parameter int OCC_W = 4,
    parameter int LEN_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] fetch_cnt,
    input logic [CNT_W-1:0] decode_cnt,
    input logic [CNT_W-1:0] issue_cnt,
    input logic [OCC_W-1:0] fq_occ,
    input logic [CNT_W-1:0] fetch_thr,
    input logic [CNT_W-1:0] decode_thr,
    input logic [CNT_W-1:0] issue_thr,
    input logic [OCC_W-1:0] fq_thr,
    input logic [LEN_W-1:0] fetch_len,
    input logic [LEN_W-1:0] decode_len,
    input logic [LEN_W-1:0] issue_len,
    input logic             fetch_stall,
    input logic             decode_stall,
    input logic             issue_stall,
    input logic             icache_en,
    input logic             bpred_en,
    input logic             membus_en,
    input logic             issue_gate
);
    logic [LEN_W:0]   run_q;
    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            len_q <= '0;
        end else begin
            run_q <= fetch_stall ? run_q + 1'b1 : '0;
            if (!fetch_stall) len_q <= fetch_len;
        end
    end

    assert_fetch_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_stall) |-> $past(fetch_cnt != '0 && fetch_cnt <= fetch_thr && fetch_len != '0));

    assert_decode_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(decode_stall) |-> $past(((decode_cnt != '0 && decode_cnt <= decode_thr) || fq_occ < fq_thr)
                                      && decode_len != '0));

    assert_issue_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(issue_stall) |-> $past(issue_cnt != '0 && issue_cnt <= issue_thr && issue_len != '0));

    assert_zero_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_stall && fetch_cnt == '0) |=> !fetch_stall);

    assert_zero_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_stall && issue_len == '0) |=> !issue_stall);

    assert_no_extend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |-> (run_q < {1'b0, len_q}));

    assert_gate_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |-> (!icache_en && !bpred_en && !membus_en));

    assert_idle_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt == '0) |=> issue_gate);
endmodule

bind throttle_ctrl throttle_chk #(.CNT_W(CNT_W), .OCC_W(OCC_W), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .fetch_cnt(fetch_cnt), .decode_cnt(decode_cnt), .issue_cnt(issue_cnt), .fq_occ(fq_occ),
    .fetch_thr(fetch_thr), .decode_thr(decode_thr), .issue_thr(issue_thr), .fq_thr(fq_thr),
    .fetch_len(fetch_len), .decode_len(decode_len), .issue_len(issue_len),
    .fetch_stall(fetch_stall), .decode_stall(decode_stall), .issue_stall(issue_stall),
    .icache_en(icache_en), .bpred_en(bpred_en), .membus_en(membus_en), .issue_gate(issue_gate)
);

// File: tb/sim_throttle_ctrl.sv
module sim_throttle_ctrl;
    localparam int CNT_W = 3;
    localparam int OCC_W = 4;
    localparam int LEN_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] fetch_cnt = '0, decode_cnt = '0, issue_cnt = '0;
    logic [OCC_W-1:0] fq_occ = '0, fq_thr = '0;
    logic [CNT_W-1:0] fetch_thr = '0, decode_thr = '0, issue_thr = '0;
    logic [LEN_W-1:0] fetch_len = '0, decode_len = '0, issue_len = '0;
    logic fetch_stall, decode_stall, issue_stall, icache_en, bpred_en, membus_en, issue_gate;

    int checks = 0;
    int fails  = 0;
    int m_f = 0, m_d = 0, m_i = 0;
    logic exp_gate = 1'b0;

    always #4 clk = ~clk;

    throttle_ctrl #(.CNT_W(CNT_W), .OCC_W(OCC_W), .LEN_W(LEN_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .fetch_cnt(fetch_cnt), .decode_cnt(decode_cnt), .issue_cnt(issue_cnt), .fq_occ(fq_occ),
        .fetch_thr(fetch_thr), .decode_thr(decode_thr), .issue_thr(issue_thr), .fq_thr(fq_thr),
        .fetch_len(fetch_len), .decode_len(decode_len), .issue_len(issue_len),
        .fetch_stall(fetch_stall), .decode_stall(decode_stall), .issue_stall(issue_stall),
        .icache_en(icache_en), .bpred_en(bpred_en), .membus_en(membus_en), .issue_gate(issue_gate)
    );

    function automatic bit in_band(int c, int t);
        return (c != 0) && (c <= t);
    endfunction

    function automatic int next_rem(int m, bit trig, int len);
        if (m > 0) return m - 1;
        if (trig && len != 0) return len;
        return 0;
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cycle(string note, int fc, int dc, int ic, int occ);
        fetch_cnt  = CNT_W'(fc);
        decode_cnt = CNT_W'(dc);
        issue_cnt  = CNT_W'(ic);
        fq_occ     = OCC_W'(occ);
        m_f = next_rem(m_f, in_band(fc, int'(fetch_thr)), int'(fetch_len));
        m_d = next_rem(m_d, in_band(dc, int'(decode_thr)) || (occ < int'(fq_thr)), int'(decode_len));
        m_i = next_rem(m_i, in_band(ic, int'(issue_thr)), int'(issue_len));
        exp_gate = (ic == 0);
        @(posedge clk);
        @(negedge clk);
        chk({note, " R2 fetch_stall"}, fetch_stall, m_f > 0);
        chk({note, " R3 decode_stall"}, decode_stall, m_d > 0);
        chk({note, " R4 issue_stall"}, issue_stall, m_i > 0);
        chk({note, " R8 icache_en"}, icache_en, !(m_f > 0));
        chk({note, " R8 bpred_en"}, bpred_en, !(m_f > 0));
        chk({note, " R8 membus_en"}, membus_en, !(m_f > 0));
        chk({note, " R9 issue_gate"}, issue_gate, exp_gate);
    endtask

    task automatic set_cfg(int ft, int dt, int it, int qt, int fl, int dl, int il);
        fetch_thr = CNT_W'(ft); decode_thr = CNT_W'(dt); issue_thr = CNT_W'(it);
        fq_thr = OCC_W'(qt);
        fetch_len = LEN_W'(fl); decode_len = LEN_W'(dl); issue_len = LEN_W'(il);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        set_cfg(2, 2, 2, 0, 2, 1, 2);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 fetch_stall", fetch_stall, 1'b0);
        chk("R1 decode_stall", decode_stall, 1'b0);
        chk("R1 issue_stall", issue_stall, 1'b0);
        chk("R1 icache_en", icache_en, 1'b1);
        chk("R1 bpred_en", bpred_en, 1'b1);
        chk("R1 membus_en", membus_en, 1'b1);
        chk("R1 issue_gate", issue_gate, 1'b0);
        rst_n = 1'b1;

        // R5 zero counts never trigger
        repeat (4) cycle("R5", 0, 0, 0, 8);
        // R10 threshold+1 quiet, threshold triggers
        cycle("R10", 3, 3, 3, 8);
        cycle("R10", 3, 4, 4, 8);
        cycle("R10", 2, 2, 2, 8);
        repeat (3) cycle("R10", 4, 4, 4, 8);
        // R7 triggers during a stall are ignored
        set_cfg(2, 2, 2, 0, 3, 2, 3);
        cycle("R7", 1, 1, 1, 8);
        repeat (3) cycle("R7", 1, 1, 1, 8);
        repeat (4) cycle("R7", 4, 4, 4, 8);
        // R6 zero length
        set_cfg(4, 4, 4, 15, 0, 0, 0);
        repeat (4) cycle("R6", 1, 2, 3, 0);
        // R3 occupancy path
        set_cfg(2, 2, 2, 4, 2, 1, 2);
        cycle("R3 occ", 4, 4, 4, 3);
        cycle("R3 occ", 4, 4, 4, 4);
        repeat (3) cycle("R3 occ", 4, 4, 4, 2);

        // random phase
        for (int blk = 0; blk < 20; blk++) begin
            set_cfg($urandom % 5, $urandom % 5, $urandom % 5, $urandom % 9,
                    $urandom % 4, $urandom % 4, $urandom % 4);
            for (int k = 0; k < 150; k++) begin
                cycle("rand", $urandom % 5, $urandom % 5, $urandom % 5, $urandom % 9);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule